// File: doc/BRIEF.md
# Multi-Output Response Space Compactor

This block folds the parallel response bits of a circuit under test into one short signature. The signature register divides the incoming data by X^4 + X + 1. A two-bit mode chooses how the response word reaches the register. In select-one mode, the single output picked by an index goes in serially. In parity mode, the XOR of all outputs goes in serially, one bit per pattern. In parallel mode, every output is XORed into its own stage, so the register acts as a multiple-input signature register. When the circuit has more outputs than the register has stages, the two serial modes are the practical choice. In select-one mode, every output needs its own run over the pattern set, so a complete test takes k passes. The signature carries over from one pass to the next.

A small controller sequences each run and has three states: IDLE, RUN and DONE. The transition IDLE->RUN is taken on `start`, and it captures the mode and the output index. RUN->DONE is taken on `finish`. DONE->RUN is taken on `start`, which captures a new mode and index and keeps the signature. A `seed_clr` pulse moves any state to IDLE and clears the signature. Compaction happens only in RUN, and only on cycles where `enable` is high. The `pass` output rises in DONE when the signature equals the `golden` input.

Top module: `resp_space_compactor`

## Requirements
- R1: Two events clear the signature to 0000 and put the controller in IDLE with `pass` low: an active-low `rst_n`, or `seed_clr` high at a clock edge. `seed_clr` takes priority over every other input.
- R2: Parity mode (`mode`=1) works as follows on each edge in RUN with `enable` high. The next signature s' is {s[2:0], ^resp}, XORed with 0011 when s[3] was 1. From zero, the five resp words 1000, 0110, 0101, 0110, 1110 leave 0010.
- R3: Parallel mode (`mode`=2) works as follows on each edge in RUN with `enable` high. The next signature s' is {s[2:0],0}, XORed with 0011 when s[3] was 1, and then XORed with resp, so that resp[i] lands in stage i. From zero, the five words of R2 leave 1011.
- R4: Select-one mode (`mode`=0) applies the R2 update with the serial bit resp[out_sel] in place of ^resp.
- R5: In RUN, a cycle with `enable` low leaves the signature unchanged.
- R6: Mode and output index are captured only by `start` in IDLE or DONE. Changing `mode` or `out_sel`, or pulsing `start`, during RUN has no effect on the compaction.
- R7: `finish` in RUN moves the controller to DONE. A pattern presented with `enable` high in that same cycle is still compacted.
- R8: `pass` is high exactly when the controller is in DONE and the signature equals `golden`. It stays low during RUN even when the values match.
- R9: `start` in DONE resumes compaction from the current signature. Four select-one passes, with `out_sel` set to 0 through 3, therefore build one combined signature.
- R10: Mode value 3 behaves as parallel mode.
- R11: In IDLE and DONE, the signature does not change, whatever `enable` and `resp` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_clr | input | 1 | Synchronous clear of the signature, returns to IDLE |
| start | input | 1 | Begin or resume a run; captures mode and out_sel |
| finish | input | 1 | End the current run |
| enable | input | 1 | Compact the present response word this cycle |
| mode | input | 2 | 0 select-one, 1 parity, 2 or 3 parallel |
| out_sel | input | 2 | Output index used in select-one mode |
| resp | input | 4 | Response bits of the circuit under test |
| golden | input | 4 | Expected fault-free signature |
| signature | output | 4 | Current signature register |
| pass | output | 1 | Signature matches golden in DONE |

## Verification
The hardest case to reach is a mode change during a run. It only shows up if the mode pins, the index pins and a stray `start` all move while RUN is active, and the signature must then still follow the mode captured at the start of the run. The stimulus starts a parity run and then drives the parallel code and a new index onto the pins. It pulses `start` and keeps feeding words, comparing against a model that holds the original mode. A second hard case is a four-pass select-one accumulation through DONE->RUN transitions, which is reached by resuming from DONE with a new index each time.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    typedef enum logic [1:0] {
        CMODE_ONE    = 2'd0,
        CMODE_PARITY = 2'd1,
        CMODE_MISR   = 2'd2,
        CMODE_MISR_B = 2'd3
    } cmode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cstate_t;
endpackage

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
    import rsc_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_clr,
    input  logic             start,
    input  logic             finish,
    input  logic [1:0]       mode_in,
    input  logic [SEL_W-1:0] sel_in,
    output cmode_t           mode_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             running,
    output logic             done
);
    cstate_t cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_IDLE: if (start)  nxt = ST_RUN;
            ST_RUN:  if (finish) nxt = ST_DONE;
            ST_DONE: if (start)  nxt = ST_RUN;
            default: nxt = ST_IDLE;
        endcase
        if (seed_clr) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_IDLE;
        else        cur <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= CMODE_ONE;
            sel_q  <= '0;
        end else if (start && !seed_clr && cur != ST_RUN) begin
            mode_q <= cmode_t'(mode_in);
            sel_q  <= sel_in;
        end
    end

    always_comb begin
        running = (cur == ST_RUN);
        done    = (cur == ST_DONE);
    end

    AST_SEL_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_RUN) |=> ($stable(mode_q) && $stable(sel_q))); // R6
    AST_FINISH_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_RUN && finish && !seed_clr) |=> (cur == ST_DONE)); // R7
    AST_SEED_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seed_clr |=> (cur == ST_IDLE)); // R1
endmodule

// File: rtl/rsc_feed.sv
module rsc_feed
    import rsc_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int SIG_W   = 4,
    parameter int SEL_W   = 2
) (
    input  cmode_t             mode,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_OUT-1:0] resp,
    output logic [SIG_W-1:0]   inject
);
    localparam int PAD_W = 2 ** SEL_W;

    logic [PAD_W-1:0] resp_pad;
    logic [SIG_W-1:0] par_bits;

    always_comb begin
        resp_pad = '0;
        resp_pad[NUM_OUT-1:0] = resp;
    end

    for (genvar gi = 0; gi < SIG_W; gi++) begin : g_inj
        if (gi < NUM_OUT) begin : g_live
            assign par_bits[gi] = resp[gi];
        end else begin : g_pad
            assign par_bits[gi] = 1'b0;
        end
    end

    always_comb begin
        inject = '0;
        unique case (mode)
            CMODE_ONE:    inject[0] = resp_pad[sel];
            CMODE_PARITY: inject[0] = ^resp;
            default:      inject    = par_bits;
        endcase
    end
endmodule

// File: rtl/rsc_sigreg.sv
module rsc_sigreg #(
    parameter int               SIG_W = 4,
    parameter logic [SIG_W-1:0] POLY  = 4'b0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [SIG_W-1:0] inject,
    output logic [SIG_W-1:0] sig
);
    logic [SIG_W-1:0] sig_nxt;
    logic             fb;

    assign fb = sig[SIG_W-1];

    for (genvar gs = 0; gs < SIG_W; gs++) begin : g_stage
        if (gs == 0) begin : g_first
            assign sig_nxt[gs] = (POLY[gs] & fb) ^ inject[gs];
        end else begin : g_rest
            assign sig_nxt[gs] = sig[gs-1] ^ (POLY[gs] & fb) ^ inject[gs];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sig <= '0;
        else if (clr)  sig <= '0;
        else if (step) sig <= sig_nxt;
    end

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sig == '0)); // R1
    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(sig)); // R5
endmodule

// File: rtl/resp_space_compactor.sv
module resp_space_compactor
    import rsc_pkg::*;
#(
    parameter int               NUM_OUT = 4,
    parameter int               SIG_W   = 4,
    parameter logic [SIG_W-1:0] POLY    = 4'b0011,
    localparam int              SEL_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_clr,
    input  logic               start,
    input  logic               finish,
    input  logic               enable,
    input  logic [1:0]         mode,
    input  logic [SEL_W-1:0]   out_sel,
    input  logic [NUM_OUT-1:0] resp,
    input  logic [SIG_W-1:0]   golden,
    output logic [SIG_W-1:0]   signature,
    output logic               pass
);
    cmode_t           mode_q;
    logic [SEL_W-1:0] sel_q;
    logic             running, done, step_en;
    logic [SIG_W-1:0] inject;

    rsc_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .seed_clr(seed_clr), .start(start),
        .finish(finish), .mode_in(mode), .sel_in(out_sel),
        .mode_q(mode_q), .sel_q(sel_q), .running(running), .done(done)
    );

    rsc_feed #(.NUM_OUT(NUM_OUT), .SIG_W(SIG_W), .SEL_W(SEL_W)) u_feed (
        .mode(mode_q), .sel(sel_q), .resp(resp), .inject(inject)
    );

    assign step_en = running & enable;

    rsc_sigreg #(.SIG_W(SIG_W), .POLY(POLY)) u_sig (
        .clk(clk), .rst_n(rst_n), .clr(seed_clr), .step(step_en),
        .inject(inject), .sig(signature)
    );

    always_comb pass = done && (signature == golden);

    AST_PASS_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (signature == golden)); // R8
    AST_PARITY_LOW_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_clr && mode_q == CMODE_PARITY) |=>
        (signature[0] == (($past(signature[SIG_W-1]) & POLY[0]) ^ $past(^resp)))); // R2
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !seed_clr) |=> $stable(signature)); // R11
endmodule

// File: tb/resp_space_compactor_test.sv
module resp_space_compactor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seed_clr = 1'b0, start = 1'b0, finish = 1'b0, enable = 1'b0;
    logic [1:0] mode = 2'd0, out_sel = 2'd0;
    logic [3:0] resp = 4'd0, golden = 4'd0;
    logic [3:0] signature;
    logic       pass;

    int n_chk = 0, n_bad = 0;
    logic [3:0] m_sig = 4'd0;
    logic       m_run = 1'b0, m_done = 1'b0;
    logic [1:0] m_mode = 2'd0, m_sel = 2'd0;
    logic [3:0] refv [5];

    always #5 clk = ~clk;

    resp_space_compactor uut (
        .clk(clk), .rst_n(rst_n), .seed_clr(seed_clr), .start(start),
        .finish(finish), .enable(enable), .mode(mode), .out_sel(out_sel),
        .resp(resp), .golden(golden), .signature(signature), .pass(pass)
    );

    function automatic logic [3:0] model_step(logic [3:0] s, logic [1:0] m,
                                              logic [1:0] sl, logic [3:0] r);
        logic [3:0] t;
        t = {s[2:0], 1'b0} ^ (s[3] ? 4'b0011 : 4'b0000);
        if (m == 2'd0)      t[0] = t[0] ^ r[sl];
        else if (m == 2'd1) t[0] = t[0] ^ (r[0] ^ r[1] ^ r[2] ^ r[3]);
        else                t = t ^ r;
        return t;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        check({tag, " signature"}, signature, m_sig);
        check({tag, " pass"}, {3'b0, pass}, {3'b0, m_done && (m_sig == golden)});
    endtask

    task automatic do_seed();
        seed_clr = 1'b1;
        @(negedge clk);
        seed_clr = 1'b0;
        m_sig = 4'd0; m_run = 1'b0; m_done = 1'b0;
    endtask

    task automatic do_start(logic [1:0] m, logic [1:0] sl);
        mode = m; out_sel = sl; start = 1'b1; enable = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (!m_run) begin
            m_mode = m; m_sel = sl; m_run = 1'b1; m_done = 1'b0;
        end
    endtask

    task automatic push(logic [3:0] r, logic en, logic fin, string tag);
        resp = r; enable = en; finish = fin;
        @(negedge clk);
        enable = 1'b0; finish = 1'b0;
        if (m_run && en) m_sig = model_step(m_sig, m_mode, m_sel, r);
        if (m_run && fin) begin m_run = 1'b0; m_done = 1'b1; end
        check_outs(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        refv[0] = 4'b1000; refv[1] = 4'b0110; refv[2] = 4'b0101;
        refv[3] = 4'b0110; refv[4] = 4'b1110;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset signature", signature, 4'd0);
        check("R1 reset pass", {3'b0, pass}, 4'd0);

        // R2 reference parity stream
        do_seed();
        do_start(2'd1, 2'd0);
        for (int i = 0; i < 5; i++) push(refv[i], 1'b1, i == 4, "R2 parity ref");
        check("R2 parity remainder", signature, 4'b0010);
        golden = 4'b0010;
        @(negedge clk);
        check("R8 pass on match", {3'b0, pass}, 4'd1);
        golden = 4'b0011;
        @(negedge clk);
        check("R8 no pass on mismatch", {3'b0, pass}, 4'd0);
        push(4'hF, 1'b1, 1'b0, "R11 done holds");

        // R3 reference parallel
        do_seed();
        do_start(2'd2, 2'd0);
        for (int i = 0; i < 5; i++) push(refv[i], 1'b1, 1'b0, "R3 parallel ref");
        check("R3 parallel remainder", signature, 4'b1011);
        golden = 4'b1011;
        @(negedge clk);
        check("R8 no pass in run", {3'b0, pass}, 4'd0);

        // Sweep over modes and indices
        golden = 4'd0;
        for (int m = 0; m < 4; m++) begin
            for (int sl = 0; sl < 4; sl++) begin
                do_seed();
                do_start(m[1:0], sl[1:0]);
                for (int i = 0; i < 16; i++) begin
                    logic [3:0] r;
                    r = 4'((i * 7 + m * 3 + sl * 5) & 15);
                    if (i % 5 == 4)      push(r, 1'b0, 1'b0, "R5 enable low hold");
                    else if (m == 0)     push(r, 1'b1, 1'b0, "R4 select-one");
                    else if (m == 1)     push(r, 1'b1, 1'b0, "R2 parity sweep");
                    else if (m == 2)     push(r, 1'b1, 1'b0, "R3 parallel sweep");
                    else                 push(r, 1'b1, 1'b0, "R10 mode3 parallel");
                end
            end
        end

        // R6 mode change during run
        do_seed();
        do_start(2'd1, 2'd0);
        push(4'b0111, 1'b1, 1'b0, "R6 before change");
        mode = 2'd2; out_sel = 2'd3;
        for (int i = 0; i < 6; i++) push(4'(i * 3 + 1), 1'b1, 1'b0, "R6 pins changed");
        do_start(2'd0, 2'd2);
        check_outs("R6 start during run");
        for (int i = 0; i < 6; i++) push(4'(i * 5 + 2), 1'b1, 1'b0, "R6 after stray start");

        // R11 idle after seed
        do_seed();
        for (int i = 0; i < 4; i++) push(4'hF, 1'b1, 1'b0, "R11 idle holds");

        // R7 finish with enable in same cycle
        do_start(2'd2, 2'd0);
        push(4'b1001, 1'b1, 1'b0, "R7 run");
        push(4'b0101, 1'b1, 1'b1, "R7 finish compacts");
        push(4'b1111, 1'b1, 1'b0, "R7 done after finish");

        // R9 four select-one passes
        do_seed();
        for (int sl = 0; sl < 4; sl++) begin
            do_start(2'd0, sl[1:0]);
            for (int i = 0; i < 5; i++) push(refv[i], 1'b1, i == 4, "R9 multi-pass");
        end
        golden = m_sig;
        @(negedge clk);
        check_outs("R9 combined signature pass");

        // R1 seed during run
        do_start(2'd2, 2'd0);
        push(4'b1011, 1'b1, 1'b0, "R1 run before seed");
        do_seed();
        check_outs("R1 seed mid-run");
        push(4'b1111, 1'b1, 1'b0, "R1 idle after seed");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule